// File: doc/BRIEF.md
# Flash read-ahead engine

This block reads a serial NOR flash by itself, without software shifting individual bytes. Software sets up a 24-bit flash byte address and a length in 32-bit words, then writes a start command. The engine drops chip select and sends an 8-bit read opcode and three address bytes, most significant bit first, on one line. It waits a programmable number of dummy clocks and then clocks in data on one, two or four lines. The data is packed into little-endian 32-bit words.

Finished words go into a 16-entry FIFO. Software empties the FIFO through a data register while watching two status flags: busy and empty. A session counts as finished only when busy has cleared and the FIFO is empty. If software falls behind, the engine holds the serial clock low at a word boundary until the FIFO has room, so no data is lost.

The opcode, lane count and dummy count apply only when the configurable-read enable is set. With the enable clear, the engine performs a plain read: opcode 0x03, one data line, no dummy clocks. Software clears the enable while it reprograms these fields and sets it again when done.

Top module: `flash_readahead`

## Requirements
- R1: The address register (index 3) keeps only bits [23:0] of the written value, and those 24 bits are the address sent in the header.
- R2: Writing 1 to bit 0 of the control register (index 0) starts a session only when the engine is idle and the length register (index 4) is nonzero. A length of zero starts nothing. A start written during a session is ignored, and the running session keeps its latched address.
- R3: The status register (index 1) has bit 0 = busy, which reads 1 from the start until the last word is captured, and bit 1 = FIFO empty.
- R4: Chip select stays low for the whole session, with exactly one falling edge per session. The header is the opcode and then address bits 23 down to 0, MSB first, on io_out[0] with io_oe = 4'b0001. The bus is not driven after the header.
- R5: With the enable set, the dummy register (index 6) gives the number of serial clocks between the last address bit and the first data bit. Zero means no dummy phase.
- R6: With the enable set, the lane register (index 7, bits [1:0]) selects the data width. 0 = one line on io_in[1]. 1 = two lines on io_in[1:0], with io_in[1] as the more significant bit. 2 = four lines on io_in[3:0], with io_in[3] as the most significant bit. 3 behaves as 0.
- R7: Each word read from the data register (index 2) is little-endian: the first flash byte is in bits [7:0] and the fourth is in [31:24]. Words come out in flash order.
- R8: With the enable (index 8, bit 0) clear, the session uses opcode 0x03, one line and no dummy clocks. With it set, the opcode register (index 5, bits [7:0]) supplies the opcode.
- R9: The FIFO holds 16 words and never overflows. While it is full in the data phase, the serial clock is held low until a word is popped.
- R10: Reading the data register while the FIFO is empty returns zero and changes no state.
- R11: After exactly the programmed number of words, chip select rises together with the capture of the last word, busy clears, and no further clocks are issued.
- R12: After reset, status reads 2 (not busy, empty), cs_n is 1, sck is 0 and io_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; a read of the data register pops the FIFO |
| reg_addr | input | 4 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for the indexed register, combinational |
| sck | output | 1 | Serial clock, idle low; one serial clock takes two core clocks |
| cs_n | output | 1 | Flash chip select, active low |
| io_out | output | 4 | Serial data out; only bit 0 is used |
| io_oe | output | 4 | Output enables for io_out |
| io_in | input | 4 | Serial data in from the flash |

## Verification
Several rules are checked on every cycle. The FIFO never takes a push while full, and an empty read leaves it empty. The clock stays low across a full-FIFO stall, and the lines are undriven during the data phase. Chip select rises only on the cycle after the last word is pushed, and a zero-length start leaves the engine idle. Other behaviour needs the bench's flash model and its scenarios: that the header carries the right opcode and the masked address, that dummy and lane settings line up data bits with the flash's output, that byte order within words is right, and that a start written during a session is ignored.

// File: rtl/frd_pkg.sv
// Shared constants and types for the flash read-ahead engine.
// Assumes a 4-bit register index and 32-bit register and FIFO words.
package frd_pkg;
    localparam int REG_AW = 4;
    localparam int WORD_W = 32;

    localparam logic [REG_AW-1:0] RG_CTRL  = 4'd0;
    localparam logic [REG_AW-1:0] RG_STAT  = 4'd1;
    localparam logic [REG_AW-1:0] RG_DATA  = 4'd2;
    localparam logic [REG_AW-1:0] RG_ADDR  = 4'd3;
    localparam logic [REG_AW-1:0] RG_LEN   = 4'd4;
    localparam logic [REG_AW-1:0] RG_OPC   = 4'd5;
    localparam logic [REG_AW-1:0] RG_DUMMY = 4'd6;
    localparam logic [REG_AW-1:0] RG_LANES = 4'd7;
    localparam logic [REG_AW-1:0] RG_FLEX  = 4'd8;

    localparam logic [7:0] PLAIN_READ_OP = 8'h03;

    typedef enum logic [1:0] {PH_IDLE, PH_HDR, PH_DUMMY, PH_DATA} phase_t;
    typedef enum logic [1:0] {LANE_X1 = 2'd0, LANE_X2 = 2'd1, LANE_X4 = 2'd2, LANE_RSV = 2'd3} lanes_t;
endpackage

// File: rtl/frd_regs.sv
// Register file of the flash read-ahead engine.
// Holds the session setup, decodes the start command and the FIFO pop,
// and multiplexes read data. Assumes single-cycle register strobes.
module frd_regs
    import frd_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int CNT_W   = 16,
    parameter int DUMMY_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    input  logic              busy,
    input  logic              fifo_empty,
    input  logic [WORD_W-1:0] fifo_head,
    output logic              start_req,
    output logic              pop_req,
    output logic [ADDR_W-1:0] cfg_addr,
    output logic [CNT_W-1:0]  cfg_len,
    output logic [7:0]        cfg_op,
    output logic [DUMMY_W-1:0] cfg_dummy,
    output logic [1:0]        cfg_lanes,
    output logic              cfg_flex
);
    // Start command: bit 0 written to the control register.
    assign start_req = reg_wr && (reg_addr == RG_CTRL) && reg_wdata[0];
    // Data register read requests a pop; the FIFO ignores it when empty.
    assign pop_req   = reg_rd && (reg_addr == RG_DATA);

    // Capture software writes to the setup registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_addr  <= '0;
            cfg_len   <= '0;
            cfg_op    <= 8'h0B;
            cfg_dummy <= DUMMY_W'(8);
            cfg_lanes <= LANE_X1;
            cfg_flex  <= 1'b0;
        end else if (reg_wr) begin
            case (reg_addr)
                RG_ADDR:  cfg_addr  <= reg_wdata[ADDR_W-1:0];
                RG_LEN:   cfg_len   <= reg_wdata[CNT_W-1:0];
                RG_OPC:   cfg_op    <= reg_wdata[7:0];
                RG_DUMMY: cfg_dummy <= reg_wdata[DUMMY_W-1:0];
                RG_LANES: cfg_lanes <= reg_wdata[1:0];
                RG_FLEX:  cfg_flex  <= reg_wdata[0];
                default:  ;
            endcase
        end
    end

    // Read-data multiplexer; an empty FIFO reads as zero.
    always_comb begin
        case (reg_addr)
            RG_STAT:  reg_rdata = {{(WORD_W-2){1'b0}}, fifo_empty, busy};
            RG_DATA:  reg_rdata = fifo_empty ? '0 : fifo_head;
            RG_ADDR:  reg_rdata = WORD_W'(cfg_addr);
            RG_LEN:   reg_rdata = WORD_W'(cfg_len);
            RG_OPC:   reg_rdata = WORD_W'(cfg_op);
            RG_DUMMY: reg_rdata = WORD_W'(cfg_dummy);
            RG_LANES: reg_rdata = WORD_W'(cfg_lanes);
            RG_FLEX:  reg_rdata = WORD_W'(cfg_flex);
            default:  reg_rdata = '0;
        endcase
    end
endmodule

// File: rtl/frd_fifo.sv
// Word FIFO between the serial sequencer and the data register.
// Assumes the writer never pushes while full (the sequencer stalls);
// a pop request on an empty FIFO is dropped.
module frd_fifo #(
    parameter int DEPTH = 16,
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop_req,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int NW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wptr, rptr;
    logic [NW-1:0]    count;
    logic             pop;

    assign pop   = pop_req && !empty;
    assign empty = (count == '0);
    assign full  = (count == NW'(DEPTH));
    assign head  = mem[rptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Storage write; no reset needed for data.
    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= push_data;
    end

    // Pointer and occupancy tracking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr  <= '0;
            rptr  <= '0;
            count <= '0;
        end else begin
            if (push) wptr <= bump(wptr);
            if (pop)  rptr <= bump(rptr);
            case ({push, pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: ;
            endcase
        end
    end

    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    // R10
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && empty && !push) |=> empty);
endmodule

// File: rtl/frd_seq.sv
// Serial sequencer: drives the header, counts dummy clocks and packs
// incoming data into little-endian words.
// Assumes mode-0 timing: outputs change while sck is low, input is
// sampled at the end of the high half. One serial clock = two core clocks.
module frd_seq
    import frd_pkg::*;
#(
    parameter int ADDR_W  = 24,
    parameter int CNT_W   = 16,
    parameter int DUMMY_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_req,
    input  logic [ADDR_W-1:0]  cfg_addr,
    input  logic [CNT_W-1:0]   cfg_len,
    input  logic [7:0]         cfg_op,
    input  logic [DUMMY_W-1:0] cfg_dummy,
    input  logic [1:0]         cfg_lanes,
    input  logic               cfg_flex,
    input  logic               fifo_full,
    output logic               push,
    output logic [WORD_W-1:0]  push_data,
    output logic               busy,
    output logic               sck,
    output logic               cs_n,
    output logic [3:0]         io_out,
    output logic [3:0]         io_oe,
    input  logic [3:0]         io_in
);
    localparam int HDR_W = 8 + ADDR_W;
    localparam int HCW   = $clog2(HDR_W) + 1;
    localparam int CW    = (HCW > DUMMY_W) ? HCW : DUMMY_W;

    phase_t              ph;
    logic                sck_q, cs_n_q;
    logic [HDR_W-1:0]    hdr_sr;
    logic [CW-1:0]       cnt;
    logic [CNT_W-1:0]    words_left;
    logic [1:0]          lanes_q;
    logic [DUMMY_W-1:0]  dummy_q;
    logic [7:0]          byte_sr, nxt_byte;
    logic [3:0]          bitpos, bpc;
    logic [1:0]          byte_idx;
    logic [23:0]         word_acc;
    logic                launch, stall, cyc_end, byte_done, last_word;
    logic [7:0]          eff_op;
    logic [1:0]          eff_lanes;
    logic [DUMMY_W-1:0]  eff_dummy;

    // Session setup chosen at launch: configured or plain read.
    assign eff_op    = cfg_flex ? cfg_op : PLAIN_READ_OP;
    assign eff_lanes = (cfg_flex && cfg_lanes != LANE_RSV) ? cfg_lanes : LANE_X1;
    assign eff_dummy = cfg_flex ? cfg_dummy : '0;

    assign launch  = start_req && (ph == PH_IDLE) && (cfg_len != '0);
    assign stall   = (ph == PH_DATA) && !sck_q && fifo_full;
    assign cyc_end = (ph != PH_IDLE) && sck_q;

    // Bits captured per serial clock for the latched lane count.
    always_comb begin
        case (lanes_q)
            LANE_X4: bpc = 4'd4;
            LANE_X2: bpc = 4'd2;
            default: bpc = 4'd1;
        endcase
    end

    // Next byte value after shifting in this cycle's lanes, MSB first.
    always_comb begin
        case (lanes_q)
            LANE_X4: nxt_byte = {byte_sr[3:0], io_in[3:0]};
            LANE_X2: nxt_byte = {byte_sr[5:0], io_in[1:0]};
            default: nxt_byte = {byte_sr[6:0], io_in[1]};
        endcase
    end

    assign byte_done = cyc_end && (ph == PH_DATA) && ((bitpos + bpc) == 4'd8);
    assign push      = byte_done && (byte_idx == 2'd3);
    assign push_data = {nxt_byte, word_acc};
    assign last_word = push && (words_left == CNT_W'(1));

    // Main phase sequencer with clock generation and data packing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ph         <= PH_IDLE;
            sck_q      <= 1'b0;
            cs_n_q     <= 1'b1;
            hdr_sr     <= '0;
            cnt        <= '0;
            words_left <= '0;
            lanes_q    <= LANE_X1;
            dummy_q    <= '0;
            byte_sr    <= '0;
            bitpos     <= '0;
            byte_idx   <= '0;
            word_acc   <= '0;
        end else if (launch) begin
            ph         <= PH_HDR;
            cs_n_q     <= 1'b0;
            sck_q      <= 1'b0;
            hdr_sr     <= {eff_op, cfg_addr};
            cnt        <= CW'(HDR_W - 1);
            words_left <= cfg_len;
            lanes_q    <= eff_lanes;
            dummy_q    <= eff_dummy;
            bitpos     <= '0;
            byte_idx   <= '0;
        end else if (ph != PH_IDLE) begin
            if (!sck_q) begin
                if (!stall) sck_q <= 1'b1;
            end else begin
                sck_q <= 1'b0;
                case (ph)
                    PH_HDR: begin
                        hdr_sr <= hdr_sr << 1;
                        if (cnt == '0) begin
                            if (dummy_q != '0) begin
                                ph  <= PH_DUMMY;
                                cnt <= CW'(dummy_q) - CW'(1);
                            end else begin
                                ph <= PH_DATA;
                            end
                        end else begin
                            cnt <= cnt - 1'b1;
                        end
                    end
                    PH_DUMMY: begin
                        if (cnt == '0) ph <= PH_DATA;
                        else           cnt <= cnt - 1'b1;
                    end
                    PH_DATA: begin
                        byte_sr <= nxt_byte;
                        if (byte_done) begin
                            bitpos   <= '0;
                            byte_idx <= byte_idx + 1'b1;
                            case (byte_idx)
                                2'd0:    word_acc[7:0]   <= nxt_byte;
                                2'd1:    word_acc[15:8]  <= nxt_byte;
                                2'd2:    word_acc[23:16] <= nxt_byte;
                                default: ;
                            endcase
                            if (push) words_left <= words_left - 1'b1;
                            if (last_word) begin
                                ph     <= PH_IDLE;
                                cs_n_q <= 1'b1;
                            end
                        end else begin
                            bitpos <= bitpos + bpc;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    assign busy   = (ph != PH_IDLE);
    assign sck    = sck_q;
    assign cs_n   = cs_n_q;
    assign io_out = {3'b000, (ph == PH_HDR) ? hdr_sr[HDR_W-1] : 1'b0};
    assign io_oe  = (ph == PH_HDR) ? 4'b0001 : 4'b0000;

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((ph == PH_DATA) && !sck_q && fifo_full) |=> !sck_q);
    // R4
    data_undriven_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ph == PH_DATA) |-> (io_oe == 4'b0000));
    // R11
    end_on_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_q) |-> $past(push));
    // R2
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_req && (cfg_len == '0) && (ph == PH_IDLE)) |=> (ph == PH_IDLE));
endmodule

// File: rtl/flash_readahead.sv
// Top of the flash read-ahead engine: register file, serial sequencer
// and word FIFO. Assumes a single clock domain and a flash in mode 0.
module flash_readahead
    import frd_pkg::*;
#(
    parameter int ADDR_W     = 24,
    parameter int CNT_W      = 16,
    parameter int DUMMY_W    = 8,
    parameter int FIFO_DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              sck,
    output logic              cs_n,
    output logic [3:0]        io_out,
    output logic [3:0]        io_oe,
    input  logic [3:0]        io_in
);
    logic               busy, fifo_empty, fifo_full, start_req, pop_req, push;
    logic [WORD_W-1:0]  fifo_head, push_data;
    logic [ADDR_W-1:0]  cfg_addr;
    logic [CNT_W-1:0]   cfg_len;
    logic [7:0]         cfg_op;
    logic [DUMMY_W-1:0] cfg_dummy;
    logic [1:0]         cfg_lanes;
    logic               cfg_flex;

    frd_regs #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DUMMY_W(DUMMY_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .busy(busy), .fifo_empty(fifo_empty), .fifo_head(fifo_head),
        .start_req(start_req), .pop_req(pop_req), .cfg_addr(cfg_addr),
        .cfg_len(cfg_len), .cfg_op(cfg_op), .cfg_dummy(cfg_dummy),
        .cfg_lanes(cfg_lanes), .cfg_flex(cfg_flex)
    );

    frd_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .DUMMY_W(DUMMY_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .cfg_addr(cfg_addr),
        .cfg_len(cfg_len), .cfg_op(cfg_op), .cfg_dummy(cfg_dummy),
        .cfg_lanes(cfg_lanes), .cfg_flex(cfg_flex), .fifo_full(fifo_full),
        .push(push), .push_data(push_data), .busy(busy), .sck(sck),
        .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
    );

    frd_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(WORD_W)) u_fifo (
        .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
        .pop_req(pop_req), .head(fifo_head), .empty(fifo_empty), .full(fifo_full)
    );
endmodule

// File: tb/sim_flash_readahead.sv
// Scoreboard bench: a driver task queues expected words for each session,
// a monitor task drains the FIFO and compares. A behavioural flash model
// captures the header and streams bytes from an address-derived pattern.
module sim_flash_readahead;
    import frd_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sck, cs_n;
    logic [3:0]  io_out, io_oe;
    logic [3:0]  io_in = '0;

    int n_chk = 0, n_bad = 0;
    bit done = 0;

    logic [31:0] exp_q[$];
    logic [7:0]  exp_op;
    logic [23:0] exp_addr;

    // flash model state
    int          rise_cnt = 0, cs_falls = 0, m_w = 1, m_dummy = 0, m_bitpos = 0;
    logic [31:0] hdr = '0;
    logic [23:0] m_addr = '0;

    always #4 clk = ~clk;

    flash_readahead u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .sck(sck), .cs_n(cs_n), .io_out(io_out), .io_oe(io_oe), .io_in(io_in)
    );

    function automatic logic [7:0] fbyte(input logic [23:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ (a[23:16] + 8'h5A);
    endfunction

    always @(negedge cs_n) begin
        rise_cnt = 0;
        cs_falls++;
    end

    always @(posedge sck) begin
        if (!cs_n) begin
            if (rise_cnt < 32) hdr = {hdr[30:0], io_out[0]};
            rise_cnt++;
        end
    end

    always @(negedge sck) begin
        #1;
        if (!cs_n && rise_cnt >= 32 + m_dummy) begin
            logic [7:0] u;
            if (rise_cnt == 32 + m_dummy) begin
                m_addr   = hdr[23:0];
                m_bitpos = 0;
            end
            u = (fbyte(m_addr) >> (8 - m_bitpos - m_w)) & 8'((1 << m_w) - 1);
            case (m_w)
                4:       io_in = u[3:0];
                2:       io_in = {2'b00, u[1:0]};
                default: io_in = {2'b00, u[0], 1'b0};
            endcase
            m_bitpos += m_w;
            if (m_bitpos == 8) begin
                m_bitpos = 0;
                m_addr   = m_addr + 1'b1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #1;
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(posedge clk); #1;
        reg_rd = 1'b0;
    endtask

    // Driver: program a session, queue the expected words, start it.
    task automatic start_session(input logic [31:0] a, input int n, input bit fx,
                                 input int lanes, input int dm, input logic [7:0] op);
        if (!fx) begin
            m_w = 1; m_dummy = 0; exp_op = 8'h03;
        end else begin
            m_w = (lanes == 2) ? 4 : (lanes == 1) ? 2 : 1;
            m_dummy = dm; exp_op = op;
        end
        exp_addr = a[23:0];
        for (int i = 0; i < n; i++) begin
            logic [23:0] b;
            b = exp_addr + 24'(4 * i);
            exp_q.push_back({fbyte(b + 24'd3), fbyte(b + 24'd2), fbyte(b + 24'd1), fbyte(b)});
        end
        cs_falls = 0;
        wr(RG_FLEX, 32'd0);
        wr(RG_ADDR, a);
        wr(RG_LEN, 32'(n));
        wr(RG_OPC, {24'd0, op});
        wr(RG_DUMMY, 32'(dm));
        wr(RG_LANES, 32'(lanes));
        wr(RG_FLEX, {31'd0, fx});
        wr(RG_CTRL, 32'd1);
    endtask

    // Monitor: drain until idle and empty, compare against the queue.
    task automatic drain(input string tag);
        logic [31:0] st, d, e;
        int guard = 0;
        forever begin
            rd(RG_STAT, st);
            if (!st[1]) begin
                rd(RG_DATA, d);
                if (exp_q.size() == 0) chk(0, {tag, " R7 extra word"}, d, 32'h0);
                else begin
                    e = exp_q.pop_front();
                    chk(d == e, {tag, " R7 word"}, d, e);
                end
            end else if (!st[0]) break;
            guard++;
            if (guard > 20000) begin
                chk(0, {tag, " R11 session never ended"}, st, 32'h2);
                break;
            end
        end
        chk(exp_q.size() == 0, {tag, " R11 word count"}, 32'(exp_q.size()), 32'd0);
        chk(hdr[31:24] == exp_op, {tag, " R4 R8 opcode"}, {24'd0, hdr[31:24]}, {24'd0, exp_op});
        chk(hdr[23:0] == exp_addr, {tag, " R1 R4 address"}, {8'd0, hdr[23:0]}, {8'd0, exp_addr});
        chk(cs_falls == 1, {tag, " R4 one select"}, 32'(cs_falls), 32'd1);
        exp_q.delete();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R11 watchdog act=%h exp=%h", 32'd0, 32'd1);
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        bit moved;
        repeat (5) @(posedge clk);
        #1;
        chk(cs_n == 1'b1, "R12 cs_n", {31'd0, cs_n}, 32'd1);
        chk(sck == 1'b0, "R12 sck", {31'd0, sck}, 32'd0);
        chk(io_oe == 4'd0, "R12 io_oe", {28'd0, io_oe}, 32'd0);
        @(negedge clk); rst_n = 1'b1;
        rd(RG_STAT, v);
        chk(v == 32'd2, "R12 R3 status", v, 32'd2);

        // R10: empty read returns zero and nothing changes
        rd(RG_DATA, v);
        chk(v == 32'd0, "R10 empty read", v, 32'd0);
        rd(RG_STAT, v);
        chk(v == 32'd2, "R10 status after empty read", v, 32'd2);

        // R1 R8: plain read, upper address bits dropped
        start_session(32'hFF12_34FE, 3, 1'b0, 2, 7, 8'hEB);
        rd(RG_STAT, v);
        chk(v[0] == 1'b1, "R3 busy during session", v, 32'd1);
        drain("plain");

        // R5 R6: dual lanes with 4 dummy clocks
        start_session(32'h0000_0100, 5, 1'b1, 1, 4, 8'h3B);
        drain("dual");

        // R6 R5: reserved lane code acts as single, zero dummy
        start_session(32'h0040_0021, 2, 1'b1, 3, 0, 8'h0B);
        drain("lane3");

        // R9: quad session longer than the FIFO, left undrained
        start_session(32'h007F_FFF0, 20, 1'b1, 2, 6, 8'h6B);
        repeat (600) @(posedge clk);
        rd(RG_STAT, v);
        chk(v == 32'd1, "R9 busy with full FIFO", v, 32'd1);
        moved = 0;
        for (int i = 0; i < 64; i++) begin
            @(negedge clk);
            if (sck) moved = 1;
        end
        chk(!moved, "R9 sck held low", {31'd0, moved}, 32'd0);
        drain("quad");

        // R2: zero length starts nothing
        wr(RG_LEN, 32'd0);
        wr(RG_CTRL, 32'd1);
        moved = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (!cs_n) moved = 1;
        end
        chk(!moved, "R2 zero length", {31'd0, moved}, 32'd0);
        rd(RG_STAT, v);
        chk(v == 32'd2, "R2 R3 status after zero length", v, 32'd2);

        // R2: start during a session is ignored
        start_session(32'h0012_0040, 2, 1'b0, 0, 0, 8'h03);
        repeat (10) @(posedge clk);
        wr(RG_ADDR, 32'h0000_0999);
        wr(RG_CTRL, 32'd1);
        drain("restart");
        moved = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (!cs_n || sck) moved = 1;
        end
        chk(!moved, "R2 R11 no second session", {31'd0, moved}, 32'd0);

        done = 1;
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end
endmodule